// File: doc/BRIEF.md
# Indexed I/O General-Purpose Strobe Port

This block sits on an ISA-style indexed register interface. It turns one socket pin into a strobe for an external latch or buffer. Software sees the external device as one more register in the indexed space. The block has three registers:

- an index register, written through the index port;
- an extended-index register, reached through the data port;
- a per-socket control register, which selects the strobe polarity, write-strobe mode, read-strobe mode and the drive style.

When the index and extended index point at the external data location, the bus read or write pulse passes straight to the pin. The pin is active for exactly as long as the pulse is low. Data written through a write strobe is also kept in a shadow register, so that software can read it back. When neither strobe mode is on, the pin becomes an input with an internal pull-up. The pull-up is off when the socket's pull-up control input is set.

Port decode uses index port 3E0h and data port 3E1h. At index 2Eh, the data port reads and writes the extended index. At the socket's index (2Fh by default, 6Fh for the second socket), extended index 0Ah selects the external data location and 0Bh selects the control register.

Top module: `gps_strobe_port`

## Requirements
- R1: After reset the index, extended-index, control and shadow registers are 0. The strobe output enable is 0. The pull-up enable is 1 while the pull-up control input is 0. A read of the index port returns 0.
- R2: A write to port 3E0h loads the index from data bits 7:0, and a read of 3E0h returns it. While the index is 2Eh, the data port writes and reads the extended index.
- R3: With control bit 4 set, index 2Fh and extended index 0Ah, the strobe is active exactly while IOW is low on a write to 3E1h. It is not active for any other index or extended-index value.
- R4: With control bit 3 set, the strobe is active exactly while IOR is low on a read of the external data location. A write to that location does not activate it when only bit 3 is set.
- R5: Control bit 5 = 0 gives an active-low strobe. Bit 5 = 1 gives a strobe that idles low and is high while active.
- R6: Control bit 2 = 1 (totem-pole) enables the output whenever a strobe mode is on. Bit 2 = 0 (open-collector) enables the output only while it is low.
- R7: The pull-up enable is 1 only when control bits 3 and 4 are both 0 and the pull-up control input is 0.
- R8: Control bits 7:6 and 1:0 always read back 0, even after a write of 1s.
- R9: With bit 4 set, a write to the external data location captures the data in the shadow register, and a read there drives the shadow onto the bus. With bit 4 clear, a write is not captured and a read leaves the bus undriven.
- R10: External data uses data bits 15:8 when the 16-bit mode input is 1, and bits 7:0 otherwise. This holds for both capture and readback. Register reads always use bits 7:0.
- R11: With bits 3 and 4 both set, a read and a write each activate the strobe, and a read returns the shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 10 | I/O address |
| iow_ni | input | 1 | Bus write pulse, active low |
| ior_ni | input | 1 | Bus read pulse, active low |
| bus16_i | input | 1 | 1 = external data on bits 15:8 |
| wdata_i | input | 16 | Write data from the bus |
| pullup_ctl_i | input | 1 | Socket pull-up control bit |
| rdata_o | output | 16 | Read data to the bus |
| rdata_oe_o | output | 1 | Read data drive enable |
| strobe_o | output | 1 | Strobe pin level |
| strobe_oe_o | output | 1 | Strobe pin output enable |
| pullup_en_o | output | 1 | Internal pull-up enable |

## Verification
The assertions assume that IOR and IOW are never low in the same cycle. They also assume that the address and write data stay steady for as long as a pulse is low, so that each pulse decodes to a single target. The bench drives every input on the falling clock edge and keeps at most one pulse low at a time. Each pulse covers one rising edge, and the address and data do not change until the pulse has been released.

// File: rtl/gps_pkg.sv
package gps_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_POL   = 5;
  localparam int BIT_WR    = 4;
  localparam int BIT_RD    = 3;
  localparam int BIT_TOTEM = 2;
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'h3C;

  typedef struct packed {
    logic pol;
    logic wr_en;
    logic rd_en;
    logic totem;
  } gps_ctrl_t;
endpackage

// File: rtl/gps_idx_decode.sv
module gps_idx_decode #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 10'h3E0,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 10'h3E1,
  parameter logic [7:0] SOCK_IDX    = 8'h2F,
  parameter logic [7:0] EXT_SEL_IDX = 8'h2E,
  parameter logic [7:0] EXT_DATA    = 8'h0A,
  parameter logic [7:0] EXT_CTRL    = 8'h0B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              iow_ni,
  input  logic              ior_ni,
  input  logic [7:0]        wbyte_i,
  output logic [7:0]        index_o,
  output logic [7:0]        ext_o,
  output logic              idx_rd_o,
  output logic              ext_rd_o,
  output logic              ctrl_wr_o,
  output logic              ctrl_rd_o,
  output logic              data_wr_o,
  output logic              data_rd_o
);
  logic [7:0] index_q, ext_q;
  logic at_idx, at_dat, sel_ext, sel_sock, sel_data, sel_ctrl;
  logic idx_wr, ext_wr;

  assign at_idx   = (io_addr_i == INDEX_PORT);
  assign at_dat   = (io_addr_i == DATA_PORT);
  assign sel_ext  = at_dat && (index_q == EXT_SEL_IDX);
  assign sel_sock = at_dat && (index_q == SOCK_IDX);
  assign sel_data = sel_sock && (ext_q == EXT_DATA);
  assign sel_ctrl = sel_sock && (ext_q == EXT_CTRL);

  assign idx_wr    = !iow_ni && at_idx;
  assign ext_wr    = !iow_ni && sel_ext;
  assign ctrl_wr_o = !iow_ni && sel_ctrl;
  assign data_wr_o = !iow_ni && sel_data;
  assign idx_rd_o  = !ior_ni && at_idx;
  assign ext_rd_o  = !ior_ni && sel_ext;
  assign ctrl_rd_o = !ior_ni && sel_ctrl;
  assign data_rd_o = !ior_ni && sel_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      ext_q   <= '0;
    end else begin
      if (idx_wr) index_q <= wbyte_i;
      if (ext_wr) ext_q   <= wbyte_i;
    end
  end

  assign index_o = index_q;
  assign ext_o   = ext_q;

  // one write target per cycle
  assert_one_target_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({idx_wr, ext_wr, ctrl_wr_o, data_wr_o}));
  // index register only moves on a write to the index port
  assert_index_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_wr |=> $stable(index_q));
endmodule

// File: rtl/gps_ctrl_shadow.sv
module gps_ctrl_shadow
  import gps_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [BYTE_W-1:0] ctrl_byte_i,
  input  logic              data_wr_i,
  input  logic [BYTE_W-1:0] data_byte_i,
  output gps_ctrl_t         ctrl_o,
  output logic [BYTE_W-1:0] ctrl_byte_o,
  output logic [BYTE_W-1:0] shadow_o
);
  logic [BYTE_W-1:0] ctrl_q, shadow_q;
  logic cap;

  assign cap = data_wr_i && ctrl_q[BIT_WR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (ctrl_wr_i) ctrl_q <= ctrl_byte_i & CTRL_MASK;
      if (cap)       shadow_q <= data_byte_i;
    end
  end

  assign ctrl_o.pol   = ctrl_q[BIT_POL];
  assign ctrl_o.wr_en = ctrl_q[BIT_WR];
  assign ctrl_o.rd_en = ctrl_q[BIT_RD];
  assign ctrl_o.totem = ctrl_q[BIT_TOTEM];
  assign ctrl_byte_o  = ctrl_q;
  assign shadow_o     = shadow_q;

  // shadow only changes on a write-strobe capture
  assert_shadow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_wr_i && ctrl_o.wr_en) |=> $stable(shadow_q));
endmodule

// File: rtl/gps_strobe_drv.sv
module gps_strobe_drv
  import gps_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  gps_ctrl_t ctrl_i,
  input  logic      data_wr_i,
  input  logic      data_rd_i,
  input  logic      pullup_ctl_i,
  output logic      strobe_o,
  output logic      strobe_oe_o,
  output logic      pullup_en_o
);
  logic mode_on, active, level;

  assign mode_on = ctrl_i.wr_en || ctrl_i.rd_en;
  assign active  = (ctrl_i.wr_en && data_wr_i) || (ctrl_i.rd_en && data_rd_i);
  // pol=0: idle high, low when active
  assign level   = ctrl_i.pol ? active : !active;

  assign strobe_o    = level;
  assign strobe_oe_o = mode_on && (ctrl_i.totem || !level);
  assign pullup_en_o = !mode_on && !pullup_ctl_i;

  assert_oc_low_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.totem && strobe_oe_o) |-> !strobe_o);
  assert_pullup_vs_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pullup_en_o |-> !strobe_oe_o);
endmodule

// File: rtl/gps_strobe_port.sv
module gps_strobe_port
  import gps_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 10'h3E0,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 10'h3E1,
  parameter logic [7:0] SOCK_IDX    = 8'h2F,
  parameter logic [7:0] EXT_SEL_IDX = 8'h2E,
  parameter logic [7:0] EXT_DATA    = 8'h0A,
  parameter logic [7:0] EXT_CTRL    = 8'h0B,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              iow_ni,
  input  logic              ior_ni,
  input  logic              bus16_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pullup_ctl_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              strobe_o,
  output logic              strobe_oe_o,
  output logic              pullup_en_o
);
  logic [BYTE_W-1:0] lo_byte, ext_byte, index_q, ext_q, ctrl_byte, shadow, rd_byte;
  logic idx_rd, ext_rd, ctrl_wr, ctrl_rd, data_wr, data_rd;
  gps_ctrl_t ctrl;

  assign lo_byte  = wdata_i[BYTE_W-1:0];
  assign ext_byte = bus16_i ? wdata_i[DATA_W-1:BYTE_W] : wdata_i[BYTE_W-1:0];

  gps_idx_decode #(
    .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT),
    .SOCK_IDX(SOCK_IDX), .EXT_SEL_IDX(EXT_SEL_IDX),
    .EXT_DATA(EXT_DATA), .EXT_CTRL(EXT_CTRL)
  ) u_dec (
    .clk_i, .rst_ni, .io_addr_i, .iow_ni, .ior_ni,
    .wbyte_i(lo_byte), .index_o(index_q), .ext_o(ext_q),
    .idx_rd_o(idx_rd), .ext_rd_o(ext_rd), .ctrl_wr_o(ctrl_wr),
    .ctrl_rd_o(ctrl_rd), .data_wr_o(data_wr), .data_rd_o(data_rd)
  );

  gps_ctrl_shadow u_reg (
    .clk_i, .rst_ni, .ctrl_wr_i(ctrl_wr), .ctrl_byte_i(lo_byte),
    .data_wr_i(data_wr), .data_byte_i(ext_byte),
    .ctrl_o(ctrl), .ctrl_byte_o(ctrl_byte), .shadow_o(shadow)
  );

  gps_strobe_drv u_drv (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .data_wr_i(data_wr), .data_rd_i(data_rd),
    .pullup_ctl_i, .strobe_o, .strobe_oe_o, .pullup_en_o
  );

  always_comb begin
    if (idx_rd)       rd_byte = index_q;
    else if (ext_rd)  rd_byte = ext_q;
    else if (ctrl_rd) rd_byte = ctrl_byte;
    else              rd_byte = shadow;
  end

  // external data read is served from the shadow only in write-strobe mode
  assign rdata_oe_o = idx_rd || ext_rd || ctrl_rd || (data_rd && ctrl.wr_en);

  always_comb begin
    rdata_o = '0;
    if (rdata_oe_o) begin
      if (data_rd && bus16_i) rdata_o[DATA_W-1:BYTE_W] = rd_byte;
      else                    rdata_o[BYTE_W-1:0]      = rd_byte;
    end
  end

  // input assumption: never both pulses at once
  assert_pulse_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!iow_ni && !ior_ni));
  // active strobe level only while a bus pulse is low
  assert_strobe_in_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_oe_o && (strobe_o == ctrl.pol)) |-> (!iow_ni || !ior_ni));
endmodule

// File: tb/tb_gps_strobe_port.sv
module tb_gps_strobe_port;
  logic clk = 0, rst_n = 0;
  logic [9:0] addr = '0;
  logic iow_n = 1, ior_n = 1, b16 = 0, puc = 0;
  logic [15:0] wdata = '0, rdata;
  logic rdata_oe, strb, strb_oe, pu_en;
  int checks = 0, errors = 0;
  logic p_s, p_oe, r_oe, i_s, i_oe;
  logic [15:0] r_d;

  always #5 clk = ~clk;

  gps_strobe_port dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .iow_ni(iow_n), .ior_ni(ior_n),
    .bus16_i(b16), .wdata_i(wdata), .pullup_ctl_i(puc), .rdata_o(rdata),
    .rdata_oe_o(rdata_oe), .strobe_o(strb), .strobe_oe_o(strb_oe), .pullup_en_o(pu_en)
  );

  // {wr, addr, data, b16, exp_rdata, exp_oe}
  localparam int NV = 16;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 10'h3E0, 16'h002E, 1'b0, 16'h0000, 1'b0},
    {1'b1, 10'h3E1, 16'h000B, 1'b0, 16'h0000, 1'b0},
    {1'b0, 10'h3E1, 16'h0000, 1'b0, 16'h000B, 1'b1},
    {1'b1, 10'h3E0, 16'h002F, 1'b0, 16'h0000, 1'b0},
    {1'b0, 10'h3E0, 16'h0000, 1'b0, 16'h002F, 1'b1},
    {1'b1, 10'h3E1, 16'h00FF, 1'b0, 16'h0000, 1'b0},
    {1'b0, 10'h3E1, 16'h0000, 1'b0, 16'h003C, 1'b1},
    {1'b1, 10'h3E1, 16'h0014, 1'b0, 16'h0000, 1'b0},
    {1'b1, 10'h3E0, 16'h002E, 1'b0, 16'h0000, 1'b0},
    {1'b1, 10'h3E1, 16'h000A, 1'b0, 16'h0000, 1'b0},
    {1'b1, 10'h3E0, 16'h002F, 1'b0, 16'h0000, 1'b0},
    {1'b1, 10'h3E1, 16'h005A, 1'b0, 16'h0000, 1'b0},
    {1'b0, 10'h3E1, 16'h0000, 1'b0, 16'h005A, 1'b1},
    {1'b1, 10'h3E1, 16'hA300, 1'b1, 16'h0000, 1'b0},
    {1'b0, 10'h3E1, 16'h0000, 1'b1, 16'hA300, 1'b1},
    {1'b0, 10'h3E1, 16'h0000, 1'b0, 16'h00A3, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; iow_n = 1; ior_n = 1;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  // p_* sampled mid pulse, i_* sampled after release
  task automatic wr(input logic [9:0] a, input logic [15:0] d, input logic w16 = 0);
    @(negedge clk); addr = a; wdata = d; b16 = w16; iow_n = 0;
    #2 p_s = strb; p_oe = strb_oe;
    @(negedge clk); iow_n = 1;
    #2 i_s = strb; i_oe = strb_oe;
  endtask

  task automatic rd(input logic [9:0] a, input logic w16 = 0);
    @(negedge clk); addr = a; b16 = w16; ior_n = 0;
    #2 p_s = strb; p_oe = strb_oe; r_d = rdata; r_oe = rdata_oe;
    @(negedge clk); ior_n = 1;
    #2 i_s = strb; i_oe = strb_oe;
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    wr(10'h3E0, 16'h002E); wr(10'h3E1, 16'h000B);
    wr(10'h3E0, 16'h002F); wr(10'h3E1, {8'h00, v});
    wr(10'h3E0, 16'h002E); wr(10'h3E1, 16'h000A);
    wr(10'h3E0, 16'h002F);
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // table walk: R2 index/ext, R8 reserved, R9 shadow, R10 lanes
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) wr(VEC[i][43:34], VEC[i][33:18], VEC[i][17]);
      else begin
        rd(VEC[i][43:34], VEC[i][17]);
        chk($sformatf("R2/R8/R9/R10 vec%0d data", i), r_d, VEC[i][16:1]);
        chk($sformatf("R2/R8/R9/R10 vec%0d oe", i), {15'd0, r_oe}, {15'd0, VEC[i][0]});
      end
    end

    do_reset();
    #2;
    chk("R1 strobe oe", {15'd0, strb_oe}, 16'd0);
    chk("R1 pullup", {15'd0, pu_en}, 16'd1);
    rd(10'h3E0);
    chk("R1 index zero", r_d, 16'h0000);
    @(negedge clk); puc = 1; #2;
    chk("R7 pullup ctl", {15'd0, pu_en}, 16'd0);
    @(negedge clk); puc = 0;

    // write mode, active-low, open-collector
    set_ctrl(8'h10);
    chk("R6 oc idle oe", {15'd0, i_oe}, 16'd0);
    chk("R7 pullup off in mode", {15'd0, pu_en}, 16'd0);
    wr(10'h3E0, 16'h002E); wr(10'h3E1, 16'h000B); wr(10'h3E0, 16'h002F);
    wr(10'h3E1, 16'h0010);
    chk("R3 no strobe at ctrl ext", {14'd0, p_s, p_oe}, 16'b10);
    wr(10'h3E0, 16'h002E); wr(10'h3E1, 16'h000A); wr(10'h3E0, 16'h002F);
    wr(10'h3E1, 16'h0042);
    chk("R3 strobe during write", {14'd0, p_s, p_oe}, 16'b01);
    chk("R3 strobe ends", {14'd0, i_s, i_oe}, 16'b10);
    rd(10'h3E1);
    chk("R4 no read strobe", {14'd0, p_s, p_oe}, 16'b10);
    chk("R9 shadow read", r_d, 16'h0042);

    // read mode, active-high, totem
    set_ctrl(8'h2C);
    #2;
    chk("R5 R6 totem idle low", {14'd0, strb, strb_oe}, 16'b01);
    rd(10'h3E1);
    chk("R4 R5 read strobe high", {14'd0, p_s, p_oe}, 16'b11);
    chk("R9 no drive without wr mode", {15'd0, r_oe}, 16'd0);
    chk("R4 strobe ends", {14'd0, i_s, i_oe}, 16'b01);
    wr(10'h3E1, 16'h0099);
    chk("R4 write ignored", {14'd0, p_s, p_oe}, 16'b01);

    // both modes
    set_ctrl(8'h18);
    rd(10'h3E1);
    chk("R11 read strobe", {14'd0, p_s, p_oe}, 16'b01);
    chk("R9 R11 shadow kept", r_d, 16'h0042);
    wr(10'h3E1, 16'h0077);
    chk("R11 write strobe", {14'd0, p_s, p_oe}, 16'b01);
    rd(10'h3E1);
    chk("R11 shadow new", r_d, 16'h0077);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule